// File: doc/BRIEF.md
# One-Wire Bus Adapter Built on a UART Frame

This block generates one-wire bus slots with a minimal 8N1 serial transmitter and receiver. The transmit pin drives the bus through an external open-drain stage, and the receive pin reads the same bus back. Each one-wire operation is a single serial frame. The block chooses the byte and the bit rate for the frame, sends it, and captures the echo. The echo carries both the host's drive and any low level that a bus device adds. The block decodes that echo into a read bit or a presence flag.

To use it, the host presents an operation code on `op` and pulses `go` while `busy` is low. `busy` stays high for the whole frame. `done` pulses for one cycle when the frame ends, and the decoded results are valid from that same cycle. The fast and slow divisors are derived from the system clock frequency parameter.

Top module: `owire_uart_adapter`

## Requirements
- R1: While idle, `tx` is high. A frame is a low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts one divisor period of clock cycles.
- R2: Operation codes `op`=0, 1 and 2 use the fast divisor, round(CLK_HZ/FAST_BAUD). Code 0 (write zero) sends 0x00. Code 1 (write one) and code 2 (read) send 0xFF.
- R3: Operation code 3 (reset/presence) sends 0xF0 with the slow divisor, round(CLK_HZ/SLOW_BAUD).
- R4: When a read completes, `bit_out` becomes 1 if the echoed byte is exactly 0xFF, and 0 for any other echo.
- R5: When a reset completes, `present` becomes 0 if the echoed byte is exactly 0xF0, and 1 for any other echo.
- R6: `go` is accepted on a clock edge where `busy` is low. `done` is high for exactly one cycle, starting ten bit periods after the accepting edge (10·divisor cycles). `busy` is high from the accepting edge until `done` rises.
- R7: A `go` pulse while `busy` is high is ignored. The running frame keeps its byte, its divisor and its timing.
- R8: `stop_err` is updated at every `done`. It goes to 1 when the echoed stop bit was sampled low, and to 0 when it was sampled high.
- R9: `bit_out` changes only when a read completes, and `present` changes only when a reset completes. Write operations leave both unchanged.
- R10: During and after reset, `busy`, `done`, `bit_out`, `present` and `stop_err` are 0 and `tx` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 2 | Operation: 0 write zero, 1 write one, 2 read, 3 reset/presence |
| go | input | 1 | Start strobe, taken when idle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| bit_out | output | 1 | Result of the last read |
| present | output | 1 | Result of the last reset/presence |
| stop_err | output | 1 | Echoed stop bit was low in the last frame |
| tx | output | 1 | Serial output to the open-drain driver |
| rx | input | 1 | Serial input from the bus |

## Verification
The bench counts falling clock edges from the edge that accepts `go`. `done` is expected on the falling edge that follows the rising edge 10·divisor cycles after acceptance, so the count must be exactly 10·divisor+1. A mismatch fails even if the decoded values are correct. The transmitted byte is sampled at the middle of each bit period, counted from the same start edge. The bench's bus device pulls the line low on whole bit windows that are aligned to that count, so every echo value can be predicted before the frame runs. The results are compared only on the `done` cycle.

// File: rtl/owire_uart_adapter.sv
module owire_uart_adapter #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int FAST_BAUD = 115_200,
  parameter int SLOW_BAUD = 9_600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] op,
  input  logic       go,
  output logic       busy,
  output logic       done,
  output logic       bit_out,
  output logic       present,
  output logic       stop_err,
  output logic       tx,
  input  logic       rx
);
  localparam int FAST_DIV = (CLK_HZ + FAST_BAUD / 2) / FAST_BAUD;
  localparam int SLOW_DIV = (CLK_HZ + SLOW_BAUD / 2) / SLOW_BAUD;
  localparam int CW       = $clog2(SLOW_DIV + 1);
  localparam logic [1:0] OP_W0 = 2'd0, OP_RD = 2'd2, OP_RST = 2'd3;

  logic [1:0]    op_q;
  logic [CW-1:0] div_q, tcnt, rcnt;
  logic [3:0]    tbit, rbit;
  logic [9:0]    tsh;
  logic [7:0]    rsh, byte_sel;
  logic          r1, r2, ract, rgot, rstop;
  logic          tlast;

  assign byte_sel = (op == OP_W0) ? 8'h00 : (op == OP_RST) ? 8'hF0 : 8'hFF;
  assign tlast    = busy && (tcnt == div_q - 1'b1) && (tbit == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; tx <= 1'b1;
      bit_out <= 1'b0; present <= 1'b0; stop_err <= 1'b0;
      op_q <= '0; div_q <= CW'(FAST_DIV); tcnt <= '0; tbit <= '0; tsh <= '1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          op_q  <= op;
          div_q <= (op == OP_RST) ? CW'(SLOW_DIV) : CW'(FAST_DIV);
          tsh   <= {1'b1, byte_sel, 1'b0};
          tx    <= 1'b0;
          tcnt  <= '0;
          tbit  <= '0;
        end
      end else if (tcnt == div_q - 1'b1) begin
        tcnt <= '0;
        if (tbit == 4'd9) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          tx       <= 1'b1;
          stop_err <= ~rstop;
          if (op_q == OP_RD)  bit_out <= (rsh == 8'hFF);
          if (op_q == OP_RST) present <= (rsh != 8'hF0);
        end else begin
          tbit <= tbit + 4'd1;
          tx   <= tsh[tbit + 4'd1];
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 <= 1'b1; r2 <= 1'b1; ract <= 1'b0; rgot <= 1'b0;
      rcnt <= '0; rbit <= '0; rsh <= '0; rstop <= 1'b1;
    end else begin
      r1 <= rx;
      r2 <= r1;
      if (!busy) begin
        ract <= 1'b0;
        rgot <= 1'b0;
      end else if (!ract && !rgot) begin
        if (!r2) begin
          ract <= 1'b1;
          rcnt <= '0;
          rbit <= '0;
        end
      end else if (ract) begin
        rcnt <= (rcnt == div_q - 1'b1) ? '0 : rcnt + 1'b1;
        if (rcnt == (div_q >> 1)) begin
          if (rbit == 4'd9) begin
            rstop <= r2;
            ract  <= 1'b0;
            rgot  <= 1'b1;
          end else begin
            if (rbit != 4'd0) rsh <= {r2, rsh[7:1]};
            rbit <= rbit + 4'd1;
          end
        end
      end
    end
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  echo_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlast |-> rgot);
  // R7
  frame_setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(div_q) && $stable(op_q) && $stable(tsh)));
  // R9
  read_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_out) |-> (done && op_q == OP_RD));
  // R9
  presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(present) |-> (done && op_q == OP_RST));
endmodule

// File: tb/owire_uart_adapter_test.sv
module owire_uart_adapter_test;
  localparam int CLK_HZ = 1_152_000;
  localparam int FB = 115_200, SB = 9_600;
  localparam int FD = (CLK_HZ + FB / 2) / FB;
  localparam int SD = (CLK_HZ + SB / 2) / SB;

  // vector: [11:10] op, [9:2] device pull mask on data bits, [1] pull stop bit, [0] stray go mid-frame
  localparam logic [11:0] VEC [10] = '{
    {2'd2, 8'h00, 1'b0, 1'b0},
    {2'd2, 8'h01, 1'b0, 1'b0},
    {2'd1, 8'h00, 1'b0, 1'b0},
    {2'd3, 8'h00, 1'b0, 1'b0},
    {2'd3, 8'h30, 1'b0, 1'b0},
    {2'd0, 8'h00, 1'b0, 1'b0},
    {2'd3, 8'h0F, 1'b0, 1'b0},
    {2'd2, 8'h80, 1'b0, 1'b1},
    {2'd2, 8'h00, 1'b1, 1'b0},
    {2'd2, 8'h00, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, pull = 1'b0;
  logic [1:0] op = '0;
  logic busy, done, bit_out, present, stop_err, tx, rx;
  int errors = 0, checks = 0;
  logic exp_rd = 1'b0, exp_pr = 1'b0;

  always #4 clk = ~clk;
  assign rx = tx & ~pull;

  owire_uart_adapter #(.CLK_HZ(CLK_HZ), .FAST_BAUD(FB), .SLOW_BAUD(SB)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .go(go), .busy(busy), .done(done),
    .bit_out(bit_out), .present(present), .stop_err(stop_err), .tx(tx), .rx(rx));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [7:0] m, input logic sp, input logic ig);
    logic [7:0] b, e;
    logic [9:0] seen;
    int d, n, idx, off;
    b = (o == 2'd0) ? 8'h00 : (o == 2'd3) ? 8'hF0 : 8'hFF;
    d = (o == 2'd3) ? SD : FD;
    e = b & ~m;
    seen = '0;
    n = 0;
    @(negedge clk); op = o; go = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      go = 1'b0;
      if (ig && n == 3 * d) begin op = ~o; go = 1'b1; end
      else op = o;
      idx = (n - 1) / d;
      off = (n - 1) % d;
      if (idx >= 1 && idx <= 8) pull = m[idx-1];
      else pull = (idx == 9) ? sp : 1'b0;
      if (idx <= 9 && off == d / 2) seen[idx] = tx;
      if (done || n > 11 * d) break;
    end
    pull = 1'b0;
    go = 1'b0;
    if (o == 2'd2) exp_rd = (e == 8'hFF);
    if (o == 2'd3) exp_pr = (e != 8'hF0);
    check(seen == {1'b1, b, 1'b0}, (o == 2'd3) ? "R3 frame" : "R1/R2 frame", seen, {1'b1, b, 1'b0});
    check(done && n == 10 * d + 1, ig ? "R7 timing with stray go" : "R6 done timing", n, 10 * d + 1);
    check(bit_out == exp_rd, (o == 2'd2) ? "R4 read bit" : "R9 read bit held", bit_out, exp_rd);
    check(present == exp_pr, (o == 2'd3) ? "R5 presence" : "R9 presence held", present, exp_pr);
    check(stop_err == sp, "R8 stop error", stop_err, sp);
    @(negedge clk);
    check(!done && !busy, "R6 done one cycle", {done, busy}, 0);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, bit_out, present, stop_err, tx} == 6'b000001, "R10 reset state",
          {busy, done, bit_out, present, stop_err, tx}, 6'b000001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx && !busy, "R1 idle line", {tx, busy}, 2'b10);
    foreach (VEC[i]) run_op(VEC[i][11:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
    // reset in the middle of a slow frame
    @(negedge clk); op = 2'd3; go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (SD * 2) @(negedge clk);
    check(busy && !tx, "R6 busy during frame", {busy, tx}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    check({busy, done, bit_out, present, stop_err, tx} == 6'b000001, "R10 mid-frame reset",
          {busy, done, bit_out, present, stop_err, tx}, 6'b000001);
    rst_n = 1'b1;
    exp_rd = 1'b0; exp_pr = 1'b0;
    run_op(2'd2, 8'h00, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule